// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block fetches 16-bit words from a 93C-style serial EEPROM over its three-wire interface. It owns the chip select, the serial clock and the data line toward the memory, and it samples the memory's data line back. The rest of the chip hands it a request carrying a half-word address (addresses count 16-bit words, not bytes). The word comes back on `rd_data` together with a one-cycle `done` pulse.

Every access is a complete frame. Chip select rises and one clock pulse goes out with the data line low. The start bit and the two-bit read opcode follow, then the address, then sixteen clock pulses that bring the word in. Chip select then drops. The serial clock runs at the core clock divided by a parameter, and the address width is a parameter so that the smaller and larger memory sizes are both covered.

A second kind of request scans the memory. It reads a configurable number of words from address 0 upward and adds them with 16-bit wraparound. It reports the contents as valid only when the final sum is zero, which is how the contents' integrity is checked at boot.

Top module: `mw_word_reader`

## Requirements
- R1: After reset, a request with `req_valid` high while `busy` is low is accepted: `busy` is high on the next cycle and stays high until the cycle in which `done` pulses, when it falls. Chip select is high only during a frame.
- R2: The first serial clock rising edge of each frame sees `ee_do` low. This is a dummy zero sent before the start bit.
- R3: The next three rising edges see `ee_do` = 1, 1, 0 (start bit, then read opcode bits 1 and 0). They are followed by `ADDR_W` address bits, most significant first.
- R4: Sixteen further clock pulses shift the word in, most significant bit first. Each bit is sampled on `ee_di` after the falling edge of its pulse. The word appears on `rd_data` in the cycle in which `done` is high, and `done` is a single-cycle pulse.
- R5: `ee_do` never changes while `ee_sk` is high, and `ee_sk` is high only while `ee_cs` is high. Every high phase of `ee_sk` lasts exactly `CLK_DIV` core cycles.
- R6: A request made while `busy` is high is ignored. No extra frame is started, and the returned word belongs to the accepted request.
- R7: A request with `req_scan` high reads addresses 0 through `SCAN_WORDS-1` in ascending order. At `done`, `rd_data` holds their 16-bit wraparound sum, and `scan_ok` is 1 exactly when that sum is zero. `scan_ok` is cleared when a scan is accepted, and plain reads leave it unchanged.
- R8: During and right after reset, `ee_cs`, `ee_sk`, `ee_do`, `busy`, `done` and `scan_ok` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only when not busy |
| req_scan | input | 1 | 1: whole-memory checksum scan, 0: single word read |
| req_addr | input | ADDR_W | Half-word address for a single read |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Word read, or the scan sum after a scan |
| scan_ok | output | 1 | Last scan summed to zero |
| ee_cs | output | 1 | Memory chip select, active high |
| ee_sk | output | 1 | Memory serial clock |
| ee_do | output | 1 | Serial data toward the memory |
| ee_di | input | 1 | Serial data from the memory |

## Verification
The assertions check the line discipline on every cycle: data never moves while the serial clock is high, the clock never pulses without chip select, `done` is a single pulse that ends `busy`, and no frame starts while idle. The frame content can only be shown by the bench's scenarios, through a behavioural memory model that checks each frame's leading zero, opcode and address order. The same applies to the returned words, the clock pulse width, the rejection of requests made while busy and the scan sums (both zero and nonzero).

// File: rtl/mwr_pkg.sv
package mwr_pkg;
  localparam int WORD_W = 16;
  localparam int HDR_W  = 4;           // dummy zero, start bit, two opcode bits
  localparam logic [HDR_W-1:0] RD_HDR = 4'b0110;

  typedef enum logic [2:0] {
    X_IDLE, X_SEL, X_TX, X_RX, X_TAIL, X_DESEL
  } xfer_st_t;

  typedef enum logic [1:0] {
    T_IDLE, T_READ, T_SCAN
  } top_st_t;
endpackage

// File: rtl/mwr_tick.sv
module mwr_tick #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en)                    cnt <= '0;
    else if (cnt == CW'(CLK_DIV - 1))  cnt <= '0;
    else                               cnt <= cnt + 1'b1;
  end

  assign tick = en && (cnt == CW'(CLK_DIV - 1));
endmodule

// File: rtl/mwr_xfer.sv
module mwr_xfer
  import mwr_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              done_o,
  output logic [WORD_W-1:0] data_o,
  output logic              cs_o,
  output logic              sk_o,
  output logic              do_o,
  input  logic              di_i
);
  localparam int TX_N  = HDR_W + ADDR_W;
  localparam int CNT_W = $clog2(TX_N + WORD_W);

  xfer_st_t          st;
  logic              hi;
  logic [TX_N-1:0]   shreg;
  logic [CNT_W-1:0]  bitcnt;
  logic              tick;

  mwr_tick #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst(rst), .en(st != X_IDLE), .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= X_IDLE; hi <= 1'b0; shreg <= '0; bitcnt <= '0;
      done_o <= 1'b0; data_o <= '0; cs_o <= 1'b0; sk_o <= 1'b0; do_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st)
        X_IDLE: if (start_i) begin
          st <= X_SEL; cs_o <= 1'b1; sk_o <= 1'b0; do_o <= 1'b0;
          shreg <= {RD_HDR, addr_i}; bitcnt <= '0; hi <= 1'b0;
        end
        X_SEL: if (tick) begin
          st <= X_TX; do_o <= shreg[TX_N-1];
        end
        X_TX: if (tick) begin
          if (!hi) begin
            sk_o <= 1'b1; hi <= 1'b1;
          end else begin
            sk_o <= 1'b0; hi <= 1'b0;
            if (bitcnt == CNT_W'(TX_N - 1)) begin
              st <= X_RX; bitcnt <= '0; do_o <= 1'b0;
            end else begin
              bitcnt <= bitcnt + 1'b1;
              shreg  <= shreg << 1;
              do_o   <= shreg[TX_N-2];
            end
          end
        end
        X_RX: if (tick) begin
          if (!hi) begin
            if (bitcnt != '0) data_o <= {data_o[WORD_W-2:0], di_i};
            sk_o <= 1'b1; hi <= 1'b1;
          end else begin
            sk_o <= 1'b0; hi <= 1'b0;
            if (bitcnt == CNT_W'(WORD_W - 1)) st <= X_TAIL;
            else                               bitcnt <= bitcnt + 1'b1;
          end
        end
        X_TAIL: if (tick) begin
          data_o <= {data_o[WORD_W-2:0], di_i};
          st <= X_DESEL; cs_o <= 1'b0;
        end
        X_DESEL: if (tick) begin
          st <= X_IDLE; done_o <= 1'b1;
        end
        default: st <= X_IDLE;
      endcase
    end
  end

  // R5: data line held while clock high
  assert_do_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    sk_o |-> $stable(do_o));
  // R5: no clock outside a selected frame
  assert_sk_in_cs_R5: assert property (@(posedge clk) disable iff (rst)
    sk_o |-> cs_o);
  // R4: completion is a single pulse
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
endmodule

// File: rtl/mw_word_reader.sv
module mw_word_reader
  import mwr_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int CLK_DIV    = 4,
  parameter int SCAN_WORDS = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_scan,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rd_data,
  output logic              scan_ok,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_do,
  input  logic              ee_di
);
  top_st_t           st;
  logic              xs_start;
  logic [ADDR_W-1:0] xs_addr;
  logic              x_done;
  logic [WORD_W-1:0] x_data;
  logic [ADDR_W-1:0] idx;
  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] acc_nxt;

  assign acc_nxt = acc + x_data;

  mwr_xfer #(.ADDR_W(ADDR_W), .CLK_DIV(CLK_DIV)) u_xfer (
    .clk(clk), .rst(rst), .start_i(xs_start), .addr_i(xs_addr),
    .done_o(x_done), .data_o(x_data),
    .cs_o(ee_cs), .sk_o(ee_sk), .do_o(ee_do), .di_i(ee_di)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= T_IDLE; busy <= 1'b0; done <= 1'b0; rd_data <= '0; scan_ok <= 1'b0;
      xs_start <= 1'b0; xs_addr <= '0; idx <= '0; acc <= '0;
    end else begin
      done     <= 1'b0;
      xs_start <= 1'b0;
      case (st)
        T_IDLE: if (req_valid) begin
          busy <= 1'b1; xs_start <= 1'b1; idx <= '0; acc <= '0;
          if (req_scan) begin
            st <= T_SCAN; xs_addr <= '0; scan_ok <= 1'b0;
          end else begin
            st <= T_READ; xs_addr <= req_addr;
          end
        end
        T_READ: if (x_done) begin
          rd_data <= x_data; done <= 1'b1; busy <= 1'b0; st <= T_IDLE;
        end
        T_SCAN: if (x_done) begin
          if (idx == ADDR_W'(SCAN_WORDS - 1)) begin
            rd_data <= acc_nxt; scan_ok <= (acc_nxt == '0);
            done <= 1'b1; busy <= 1'b0; st <= T_IDLE;
          end else begin
            acc <= acc_nxt; idx <= idx + 1'b1;
            xs_addr <= idx + 1'b1; xs_start <= 1'b1;
          end
        end
        default: st <= T_IDLE;
      endcase
    end
  end

  // R1: busy falls only together with done
  assert_busy_end_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  // R1: busy rises only on a request
  assert_busy_start_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(req_valid));
  // R6: no frame is launched while idle
  assert_no_stray_frame_R6: assert property (@(posedge clk) disable iff (rst)
    xs_start |-> busy);
endmodule

// File: tb/test_mw_word_reader.sv
module test_mw_word_reader;
  localparam int AW  = 5;
  localparam int DIV = 2;
  localparam int SW  = 32;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_scan = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic busy, done, scan_ok, ee_cs, ee_sk, ee_do;
  logic ee_di = 1'b0;
  logic [15:0] rd_data;

  mw_word_reader #(.ADDR_W(AW), .CLK_DIV(DIV), .SCAN_WORDS(SW)) i_mw_word_reader (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_scan(req_scan),
    .req_addr(req_addr), .busy(busy), .done(done), .rd_data(rd_data),
    .scan_ok(scan_ok), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_do(ee_do), .ee_di(ee_di)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [15:0] mem [SW];

  // memory model state
  int m_edge = 0, m_frames = 0, m_err_hdr = 0, m_err_cs = 0, m_err_order = 0;
  logic [AW-1:0] m_addr = '0, m_last_addr = '0;
  bit scan_chk = 0;
  int scan_next = 0;
  int hi_cnt = 0, width_err = 0, busy_gap = 0;
  bit in_req = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] sum_mem();
    logic [15:0] s = '0;
    for (int i = 0; i < SW; i++) s = s + mem[i];
    return s;
  endfunction

  always @(posedge ee_cs) m_edge = 0;

  always @(posedge ee_sk) begin
    if (!ee_cs) m_err_cs++;
    else begin
      if (m_edge == 0 && ee_do != 1'b0) m_err_hdr++;                  // R2
      if ((m_edge == 1 || m_edge == 2) && ee_do != 1'b1) m_err_hdr++; // R3
      if (m_edge == 3 && ee_do != 1'b0) m_err_hdr++;                  // R3
      if (m_edge >= 4 && m_edge < 4 + AW) begin
        m_addr = {m_addr[AW-2:0], ee_do};
        if (m_edge == 4 + AW - 1) begin
          m_frames++; m_last_addr = m_addr; ee_di <= 1'b0;
          if (scan_chk) begin
            if (int'(m_addr) != scan_next) m_err_order++;
            scan_next++;
          end
        end
      end
      if (m_edge >= 4 + AW && m_edge < 4 + AW + 16)
        ee_di <= mem[m_addr][15 - (m_edge - 4 - AW)];
      m_edge++;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (ee_sk) hi_cnt++;
    else if (hi_cnt != 0) begin
      if (hi_cnt != DIV) width_err++;
      hi_cnt = 0;
    end
    if (in_req && !busy && !done) busy_gap++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic wait_done();
    while (!done) @(negedge clk);
    in_req = 0;
  endtask

  task automatic issue(input bit scan, input logic [AW-1:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_scan = scan; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0; req_scan = 1'b0;
    in_req = 1;
    check(busy == 1'b1, "R1 busy after accept", busy, 1);
  endtask

  task automatic read_chk(input logic [AW-1:0] a);
    int f0 = m_frames;
    issue(1'b0, a);
    wait_done();
    check(rd_data == mem[a], "R4 read word", rd_data, mem[a]);
    check(m_last_addr == a, "R3 address sent", m_last_addr, a);
    check(m_frames == f0 + 1, "R1 one frame per read", m_frames - f0, 1);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R4 done single pulse", done, 0);
  endtask

  initial begin
    logic [15:0] s;
    int f0;
    bit ok_before;
    void'($urandom(32'd1234));
    for (int i = 0; i < SW; i++) mem[i] = 16'($urandom);
    repeat (3) @(negedge clk);
    // R8 reset state
    check({ee_cs, ee_sk, ee_do, busy, done, scan_ok} == 6'b0, "R8 reset outputs",
          {ee_cs, ee_sk, ee_do, busy, done, scan_ok}, 0);
    rst = 1'b0;
    @(negedge clk);
    check({ee_cs, ee_sk, ee_do, busy, done, scan_ok} == 6'b0, "R8 after reset",
          {ee_cs, ee_sk, ee_do, busy, done, scan_ok}, 0);

    // directed corners then random reads (R3 R4)
    mem[0] = 16'h8001; mem[SW-1] = 16'hFFFF; mem[1] = 16'h0000;
    read_chk('0);
    read_chk(AW'(SW - 1));
    read_chk(AW'(1));
    for (int k = 0; k < 20; k++) read_chk(AW'($urandom % SW));

    // R6: requests while busy are ignored
    f0 = m_frames;
    issue(1'b0, AW'(3));
    repeat (10) @(negedge clk);
    req_valid = 1'b1; req_addr = AW'(7);
    @(negedge clk);
    req_scan = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_scan = 1'b0;
    wait_done();
    check(rd_data == mem[3], "R6 word of accepted request", rd_data, mem[3]);
    repeat (4 * DIV + 4) @(negedge clk);
    check(m_frames == f0 + 1, "R6 no extra frame", m_frames - f0, 1);
    check(ee_cs == 1'b0, "R6 select idle", ee_cs, 0);

    // R7: scan with zero sum
    s = '0;
    for (int i = 0; i < SW - 1; i++) s = s + mem[i];
    mem[SW-1] = -s;
    scan_chk = 1; scan_next = 0; f0 = m_frames;
    issue(1'b1, '0);
    wait_done();
    scan_chk = 0;
    check(scan_ok == 1'b1, "R7 zero sum valid", scan_ok, 1);
    check(rd_data == 16'h0000, "R7 zero sum value", rd_data, 0);
    check(m_frames == f0 + SW, "R7 word count", m_frames - f0, SW);
    check(m_err_order == 0, "R7 ascending order", m_err_order, 0);
    // plain read leaves scan_ok alone
    read_chk(AW'(5));
    check(scan_ok == 1'b1, "R7 read keeps flag", scan_ok, 1);

    // R7: scan with nonzero sum
    mem[2] = mem[2] + 16'h0101;
    scan_chk = 1; scan_next = 0;
    issue(1'b1, '0);
    @(negedge clk);
    ok_before = scan_ok;
    check(ok_before == 1'b0, "R7 flag cleared at scan start", ok_before, 0);
    wait_done();
    scan_chk = 0;
    check(scan_ok == 1'b0, "R7 nonzero sum invalid", scan_ok, 0);
    check(rd_data == sum_mem(), "R7 nonzero sum value", rd_data, sum_mem());
    check(m_err_order == 0, "R7 ascending order again", m_err_order, 0);

    // frame discipline over the whole run
    check(m_err_hdr == 0, "R2 R3 dummy zero and opcode", m_err_hdr, 0);
    check(m_err_cs == 0, "R5 clock only with select", m_err_cs, 0);
    check(width_err == 0, "R5 clock high width", width_err, 0);
    check(busy_gap == 0, "R1 busy held until done", busy_gap, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule